// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Register Slave

This block is the configuration port of a clock-generator core. A host writes it over a two-wire serial bus (a clock line and an open-drain data line) using block-write framing. The slave answers one fixed 8-bit address byte, 0xD2, which already carries the write direction bit. It swallows the command and length bytes that follow without using them. It then stores up to eight data bytes, in arrival order, into an eight-byte register bank. That bank drives the clock-output enables, a global three-state control, the hardware/software frequency-select choice, a five-bit software frequency code and the 24/48 MHz select as parallel outputs.

Both bus lines are sampled into the fast system clock through two-flop synchronisers. Start and stop conditions are decoded from the synchronised lines. The slave acknowledges by pulling the data line low.

The block has no read path. Any other address is refused, and the slave then stays silent until the next start condition. Bytes are committed one at a time, so a transfer cut short by a stop keeps whatever it has already delivered.

Top module: `cfg_smbus_slave`

## Requirements
- R1: After reset the eight-byte bank holds, from register 7 down to register 0: 00 00 13 00 37 5F 0B 04 (hex). Register 0 is the low byte of `cfg_bank`. All clock-output enable bits read 1. The frequency code bit SEL_4 (register 0 bit 2) reads 1. Every other bit reads 0.
- R2: Only the address byte 0xD2 is acknowledged. A transfer with any other address byte leaves every register unchanged and receives no acknowledge.
- R3: The two bytes after an accepted address (command and length) are acknowledged, and their values reach no register.
- R4: Data bytes are taken MSB first and written in arrival order into registers 0, 1, 2 and so on.
- R5: A data byte is committed on the SCL rise that carries its eighth bit. A stop condition that cuts a transfer short, including one in the middle of a byte, keeps the registers already written and leaves the rest untouched.
- R6: For every accepted byte, `sda_pull` rises after the SCL fall that ends the eighth bit. It falls after the SCL fall that ends the ninth (acknowledge) clock. It is 0 at all other times.
- R7: Data bytes beyond the eighth are neither acknowledged nor stored.
- R8: A start condition at any point, including mid-byte, abandons the current frame and begins a new address phase.
- R9: `sw_freq_sel` = register 0 bit 3 and `tristate_all` = register 0 bit 0. `freq_sel[4:0]` = {reg0[2], reg0[1], reg0[6], reg0[5], reg0[4]}, which is SEL_4 down to SEL_0. `sel_48mhz` = register 3 bit 6 (1 selects 48 MHz).
- R10: After a refused address, all further bus traffic is ignored until the next start condition, even a byte equal to 0xD2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock line as received |
| sda_in | input | 1 | Serial data line as received (wired level) |
| sda_pull | output | 1 | 1 drives the data line low (acknowledge) |
| cfg_bank | output | 64 | Register bank, register n at bits 8n+7..8n |
| sw_freq_sel | output | 1 | 1 = frequency from software code, 0 = from straps |
| freq_sel | output | 5 | Software frequency code SEL_4..SEL_0 |
| tristate_all | output | 1 | 1 = all clock outputs three-stated |
| sel_48mhz | output | 1 | 1 = 48 MHz, 0 = 24 MHz on the dual-rate output |

## Verification
Committing a data byte and arming its acknowledge happen in the same cycle. The SCL rise that carries a byte's eighth bit both writes the register and schedules the low drive of the data line. The bench provokes this on every data byte, including the eighth (stored and acknowledged) and the ninth and tenth (neither). It also provokes it for mid-byte stops and restarts. Each clock, the register outputs, the decoded fields and the acknowledge drive are compared against a model that schedules both effects from the cycle in which the bench moved SCL.

// File: rtl/cfg_smbus_slave.sv
module cfg_smbus_slave #(
  parameter logic [7:0] DEV_ADDR = 8'hD2,
  parameter int NREG = 8,
  parameter logic [NREG*8-1:0] RESET_IMAGE = 64'h0000_1300_375F_0B04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [NREG*8-1:0] cfg_bank,
  output logic              sw_freq_sel,
  output logic [4:0]        freq_sel,
  output logic              tristate_all,
  output logic              sel_48mhz
);
  localparam int IW = $clog2(NREG + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_CNT, ST_DATA, ST_IGNORE} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  st_t        state;
  logic [2:0] bit_cnt;
  logic [6:0] shift;
  logic [1:0] ack_ph;
  logic [IW-1:0] byte_idx;
  logic [NREG*8-1:0] cfg_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end

  wire scl_s    = scl_sync[1];
  wire sda_s    = sda_sync[1];
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire [7:0] rx_byte = {shift, sda_s};
  wire shifting = scl_rise && (ack_ph == 2'd0) &&
                  (state inside {ST_ADDR, ST_CMD, ST_CNT, ST_DATA});
  wire last_bit = shifting && (bit_cnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shift    <= '0;
      ack_ph   <= '0;
      byte_idx <= '0;
      sda_pull <= 1'b0;
      cfg_q    <= RESET_IMAGE;
    end else if (start_c) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      ack_ph   <= '0;
      byte_idx <= '0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      state    <= ST_IDLE;
      ack_ph   <= '0;
      sda_pull <= 1'b0;
    end else begin
      if (shifting) begin
        shift   <= rx_byte[6:0];
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (last_bit) begin
        case (state)
          ST_ADDR:
            if (rx_byte == DEV_ADDR) begin
              state  <= ST_CMD;
              ack_ph <= 2'd1;
            end else state <= ST_IGNORE;
          ST_CMD: begin
            state  <= ST_CNT;
            ack_ph <= 2'd1;
          end
          ST_CNT: begin
            state  <= ST_DATA;
            ack_ph <= 2'd1;
          end
          default:
            if (byte_idx < IW'(NREG)) begin
              for (int i = 0; i < NREG; i++)
                if (byte_idx == IW'(i)) cfg_q[i*8 +: 8] <= rx_byte;
              byte_idx <= byte_idx + IW'(1);
              ack_ph   <= 2'd1;
            end else state <= ST_IGNORE;
        endcase
      end
      if (scl_fall) begin
        if (ack_ph == 2'd1) begin
          sda_pull <= 1'b1;
          ack_ph   <= 2'd2;
        end else if (ack_ph == 2'd2) begin
          sda_pull <= 1'b0;
          ack_ph   <= 2'd0;
        end
      end
    end

  assign cfg_bank     = cfg_q;
  assign sw_freq_sel  = cfg_q[3];
  assign tristate_all = cfg_q[0];
  assign freq_sel     = {cfg_q[2], cfg_q[1], cfg_q[6], cfg_q[5], cfg_q[4]};
  assign sel_48mhz    = cfg_q[30];

  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> cfg_q == RESET_IMAGE); // R1
  AST_IGNORED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |=> $stable(cfg_q)); // R10
  AST_WRITE_ON_EIGHTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> $past(last_bit && state == ST_DATA)); // R5
  AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s); // R6
  AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sda_pull); // R2
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    byte_idx <= IW'(NREG)); // R7
endmodule

// File: tb/sim_cfg_smbus_slave.sv
module sim_cfg_smbus_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [63:0] cfg_bank;
  logic sw_freq_sel, tristate_all, sel_48mhz;
  logic [4:0] freq_sel;
  wire sda_line = sda_m & ~sda_pull;

  cfg_smbus_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .cfg_bank(cfg_bank), .sw_freq_sel(sw_freq_sel),
    .freq_sel(freq_sel), .tristate_all(tristate_all), .sel_48mhz(sel_48mhz)
  );

  always #4 clk = ~clk;

  localparam int Q = 3;
  localparam int H = 8;
  localparam int LAT = 3;
  localparam logic [63:0] DEFAULTS = 64'h0000_1300_375F_0B04;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase_req = "R1";
  logic [63:0] exp_bank = DEFAULTS;
  logic exp_ack = 1'b0;
  int q_due[$];
  int q_idx[$];
  logic [7:0] q_val[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      while (q_due.size() > 0 && q_due[0] <= cyc) begin
        if (q_idx[0] == 8) exp_ack = 1'b1;
        else if (q_idx[0] == 9) exp_ack = 1'b0;
        else exp_bank[q_idx[0]*8 +: 8] = q_val[0];
        void'(q_due.pop_front());
        void'(q_idx.pop_front());
        void'(q_val.pop_front());
      end
      chk(cfg_bank == exp_bank, phase_req, "bank", cfg_bank, exp_bank);
      chk(sda_pull == exp_ack, "R6", "ack drive", 64'(sda_pull), 64'(exp_ack));
      chk({sw_freq_sel, tristate_all, sel_48mhz, freq_sel} ==
          {exp_bank[3], exp_bank[0], exp_bank[30],
           exp_bank[2], exp_bank[1], exp_bank[6], exp_bank[5], exp_bank[4]},
          "R9", "fields", 64'({sw_freq_sel, tristate_all, sel_48mhz, freq_sel}),
          64'({exp_bank[3], exp_bank[0], exp_bank[30], exp_bank[2], exp_bank[1],
               exp_bank[6], exp_bank[5], exp_bank[4]}));
    end
  end

  task automatic push(input int due, input int idx, input logic [7:0] v);
    q_due.push_back(due);
    q_idx.push_back(idx);
    q_val.push_back(v);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start;
    wait_n(Q); sda_m = 1'b1;
    wait_n(Q); scl_m = 1'b1;
    wait_n(Q); sda_m = 1'b0;
    wait_n(Q); scl_m = 1'b0;
  endtask

  task automatic do_stop;
    wait_n(Q); sda_m = 1'b0;
    wait_n(Q); scl_m = 1'b1;
    wait_n(Q); sda_m = 1'b1;
    wait_n(H);
  endtask

  task automatic send(input logic [7:0] b, input int nbits, input bit ack, input int reg_idx);
    for (int i = 0; i < nbits; i++) begin
      wait_n(Q); sda_m = b[7-i];
      wait_n(Q); scl_m = 1'b1;
      if (i == 7 && reg_idx >= 0) push(cyc + LAT, reg_idx, b);
      wait_n(H); scl_m = 1'b0;
    end
    if (nbits == 8) begin
      if (ack) push(cyc + LAT, 8, 8'h00);
      wait_n(Q); sda_m = 1'b1;
      wait_n(Q); scl_m = 1'b1;
      wait_n(H); scl_m = 1'b0;
      if (ack) push(cyc + LAT, 9, 8'h00);
    end
  endtask

  task automatic frame(input logic [7:0] addr, input int n, input logic [7:0] d [12],
                       input bit stop);
    bit match = (addr == 8'hD2);
    do_start();
    send(addr, 8, match, -1);
    send(8'hA5, 8, match, -1);
    send(8'h08, 8, match, -1);
    for (int i = 0; i < n; i++)
      send(d[i], 8, match && i < 8, (match && i < 8) ? i : -1);
    if (stop) do_stop();
  endtask

  task automatic settle_check(input string req);
    wait_n(10);
    chk(cfg_bank == exp_bank && q_due.size() == 0, req, "final bank", cfg_bank, exp_bank);
  endtask

  initial begin
    logic [7:0] d [12];
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    chk(cfg_bank == DEFAULTS, "R1", "reset bank", cfg_bank, DEFAULTS);
    chk(!sda_pull, "R1", "reset ack", 64'(sda_pull), 64'd0);

    phase_req = "R4 R3";
    for (int i = 0; i < 12; i++) d[i] = 8'(8'h11 * (i + 1));
    frame(8'hD2, 8, d, 1);
    settle_check("R4");
    chk(cfg_bank[7:0] == 8'h11, "R3", "cmd not stored", cfg_bank[7:0], 8'h11);

    phase_req = "R2";
    for (int i = 0; i < 12; i++) d[i] = 8'hFF;
    frame(8'hD3, 3, d, 1);
    frame(8'h52, 3, d, 1);
    settle_check("R2");

    phase_req = "R10";
    do_start();
    send(8'h90, 8, 0, -1);
    send(8'hD2, 8, 0, -1);
    send(8'hA5, 8, 0, -1);
    send(8'h00, 8, 0, -1);
    do_stop();
    settle_check("R10");

    phase_req = "R5";
    for (int i = 0; i < 12; i++) d[i] = 8'(8'hC0 + i);
    frame(8'hD2, 3, d, 1);
    settle_check("R5");
    do_start();
    send(8'hD2, 8, 1, -1);
    send(8'h00, 8, 1, -1);
    send(8'h00, 8, 1, -1);
    send(8'h3C, 8, 1, 0);
    send(8'h99, 4, 0, -1);
    do_stop();
    settle_check("R5");

    phase_req = "R7";
    for (int i = 0; i < 12; i++) d[i] = 8'(8'h21 + 8'd3 * i);
    frame(8'hD2, 10, d, 1);
    settle_check("R7");

    phase_req = "R8";
    do_start();
    send(8'hD2, 8, 1, -1);
    send(8'h00, 8, 1, -1);
    send(8'h55, 3, 0, -1);
    for (int i = 0; i < 12; i++) d[i] = 8'(8'h80 - i);
    frame(8'hD2, 2, d, 1);
    settle_check("R8");

    phase_req = "R9";
    d[0] = 8'b0101_1011; d[1] = 8'h00; d[2] = 8'h00; d[3] = 8'h40;
    frame(8'hD2, 4, d, 1);
    settle_check("R9");
    chk(freq_sel == 5'b01101 && sw_freq_sel && tristate_all && sel_48mhz, "R9",
        "decoded fields", 64'({freq_sel, sw_freq_sel, tristate_all, sel_48mhz}),
        64'({5'b01101, 3'b111}));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule